// File: doc/BRIEF.md
# Shared Line Occupancy and Extension Pickup Detector

This block decides whether a telephone line shared with other handsets is busy. Its input is a stream of 8-bit DC line voltage codes from an auxiliary converter; a new code arrives roughly every 400 µs, marked by a one-cycle valid strobe. Every decision uses the mean of a power-of-two group of codes, so the division is a right shift. Thresholds and margins are raw converter codes on configuration inputs, so no voltage scaling takes place inside the block.

While the hook input shows on-hook, the block averages back-to-back groups of codes and compares each mean against a programmable busy threshold. A low mean means another handset holds the line, so going off-hook is not permitted. A mean at or above the threshold means the line is idle and off-hook may proceed. Once the hook input shows off-hook, the block drops a set number of settling codes and averages the next group to form a reference. It then watches each code for a sudden drop below that reference. A drop starts a confirmation group of fresh codes. If the mean of that group is well below the reference, a pickup flag is raised and held so the host can release the line.

The controller is a state machine with six states. S_ONHOOK averages groups for the busy verdict. S_SETTLE discards settling codes. S_CAPTURE averages the reference. S_MONITOR looks for a trigger code. S_CONFIRM averages the confirmation group. S_RELEASE holds the pickup flag. The transitions are:
- hook-up: any on-hook state to S_SETTLE.
- settled: S_SETTLE to S_CAPTURE.
- ref-done: S_CAPTURE to S_MONITOR.
- trigger: S_MONITOR to S_CONFIRM.
- reject: S_CONFIRM back to S_MONITOR.
- confirm: S_CONFIRM to S_RELEASE.
- hook-down: any off-hook state to S_ONHOOK.

Top module: `line_sense_top`

## Requirements
- R1: After reset, line_busy, line_free and pickup are all 0.
- R2: On-hook, when a group of 2^AVG_LOG2 accepted codes completes, line_busy becomes 1 and line_free becomes 0 if the mean (sum shifted right by AVG_LOG2) is below busy_thresh. The new values are visible after the clock edge that accepts the last code of the group.
- R3: On-hook, a completed group whose mean is greater than or equal to busy_thresh sets line_free to 1 and line_busy to 0.
- R4: On-hook verdicts change only when a group completes. Groups follow one another without overlap, and a partial group leaves both flags unchanged.
- R5: A cycle with smp_vld low has no effect on any flag or any group in progress.
- R6: At the first clock edge that sees off_hook high, line_busy and line_free clear and stay 0 while off-hook. The first SETTLE_CNT codes are discarded, and the mean of the next 2^AVG_LOG2 codes becomes the reference.
- R7: While monitoring, a code with code + trig_margin < reference starts a confirmation group; that trigger code itself is not part of the group. A code with code + trig_margin >= reference is not a trigger.
- R8: When a confirmation group completes, pickup becomes 1 if mean + pickup_margin < reference, and it stays 1 while off-hook. Otherwise pickup stays 0 and monitoring resumes.
- R9: At the first clock edge that sees off_hook low, pickup clears, the reference is forgotten, any partial group is discarded, and on-hook averaging starts from an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | One-cycle strobe marking a new converter code |
| smp_code | input | DATA_W | Line DC voltage code |
| off_hook | input | 1 | 1 while the local equipment holds the line |
| busy_thresh | input | DATA_W | On-hook busy threshold code |
| trig_margin | input | DATA_W | Drop below the reference that starts confirmation |
| pickup_margin | input | DATA_W | Drop of the confirmed mean that flags a pickup |
| line_busy | output | 1 | On-hook verdict: line held by another handset |
| line_free | output | 1 | On-hook verdict: line idle, off-hook permitted |
| pickup | output | 1 | Off-hook: an extension has picked up |

## Verification
The bench places means exactly on the busy threshold, so a design that uses the wrong comparison sense reports busy on an idle line. It sends codes that equal the trigger and pickup boundaries, and it gives the trigger code a value that would tip the confirmation mean if it were counted. A detector that folds the trigger code into the confirmation group, or that counts the settling codes, therefore raises or misses pickup. Partial groups are left behind across a hook change, so a design that keeps stale partial sums gives a wrong first on-hook verdict. Random codes and thresholds, drawn from a fixed seed, then exercise the mean arithmetic broadly.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
    typedef enum logic [2:0] {
        S_ONHOOK  = 3'd0,
        S_SETTLE  = 3'd1,
        S_CAPTURE = 3'd2,
        S_MONITOR = 3'd3,
        S_CONFIRM = 3'd4,
        S_RELEASE = 3'd5
    } lsd_state_t;
endpackage

// File: rtl/lsd_avg.sv
module lsd_avg #(
    parameter int DATA_W   = 8,
    parameter int AVG_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [DATA_W-1:0] code,
    output logic              done,
    output logic [DATA_W-1:0] mean
);
    localparam int ACC_W = DATA_W + AVG_LOG2;
    localparam int GRP   = 1 << AVG_LOG2;

    logic [AVG_LOG2-1:0] cnt_q;
    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    sum;

    assign sum  = acc_q + ACC_W'(code);
    assign done = take && (&cnt_q);
    assign mean = DATA_W'(sum >> AVG_LOG2);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            if (&cnt_q) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= sum;
            end
        end
    end

    // R4: a partial sum never exceeds GRP-1 full-scale codes
    p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_W'((GRP - 1) * ((1 << DATA_W) - 1)));

    // R5: without a strobe or clear the group does not move
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
    import lsd_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETTLE_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_code,
    input  logic              off_hook,
    input  logic [DATA_W-1:0] busy_thresh,
    input  logic [DATA_W-1:0] trig_margin,
    input  logic [DATA_W-1:0] pickup_margin,
    input  logic              grp_done,
    input  logic [DATA_W-1:0] grp_mean,
    output logic              grp_clr,
    output logic              grp_take,
    output logic              line_busy,
    output logic              line_free,
    output logic              pickup
);
    localparam int SC_W = (SETTLE_CNT < 2) ? 1 : $clog2(SETTLE_CNT + 1);

    lsd_state_t        state_q, state_d;
    logic [SC_W-1:0]   settle_q;
    logic [DATA_W-1:0] ref_q;
    logic              hook_chg;
    logic              trig_hit;
    logic              drop_hit;

    assign hook_chg = off_hook ? (state_q == S_ONHOOK) : (state_q != S_ONHOOK);
    assign grp_clr  = hook_chg;
    assign grp_take = smp_vld && !hook_chg &&
                      (state_q == S_ONHOOK || state_q == S_CAPTURE || state_q == S_CONFIRM);
    assign trig_hit = ({1'b0, smp_code} + {1'b0, trig_margin}) < {1'b0, ref_q};
    assign drop_hit = ({1'b0, grp_mean} + {1'b0, pickup_margin}) < {1'b0, ref_q};

    always_comb begin
        state_d = state_q;
        if (hook_chg) begin
            state_d = off_hook ? S_SETTLE : S_ONHOOK;
        end else begin
            unique case (state_q)
                S_ONHOOK:  state_d = S_ONHOOK;
                S_SETTLE:  if (smp_vld && settle_q == SC_W'(SETTLE_CNT - 1)) state_d = S_CAPTURE;
                S_CAPTURE: if (grp_done) state_d = S_MONITOR;
                S_MONITOR: if (smp_vld && trig_hit) state_d = S_CONFIRM;
                S_CONFIRM: if (grp_done) state_d = drop_hit ? S_RELEASE : S_MONITOR;
                S_RELEASE: state_d = S_RELEASE;
                default:   state_d = S_ONHOOK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_ONHOOK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q  <= '0;
            ref_q     <= '0;
            line_busy <= 1'b0;
            line_free <= 1'b0;
            pickup    <= 1'b0;
        end else if (hook_chg) begin
            settle_q  <= '0;
            ref_q     <= '0;
            line_busy <= 1'b0;
            line_free <= 1'b0;
            pickup    <= 1'b0;
        end else begin
            unique case (state_q)
                S_ONHOOK: if (grp_done) begin
                    line_busy <= (grp_mean < busy_thresh);
                    line_free <= !(grp_mean < busy_thresh);
                end
                S_SETTLE: if (smp_vld) begin
                    settle_q <= (settle_q == SC_W'(SETTLE_CNT - 1)) ? '0 : settle_q + 1'b1;
                end
                S_CAPTURE: if (grp_done) ref_q <= grp_mean;
                S_MONITOR: ;
                S_CONFIRM: if (grp_done && drop_hit) pickup <= 1'b1;
                S_RELEASE: ;
                default: ;
            endcase
        end
    end

    // R2: the two on-hook verdicts never both hold
    p_verdict_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_busy && line_free));

    // R6: off-hook suppresses the on-hook verdicts from the next edge on
    p_offhook_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_hook |=> (!line_busy && !line_free));

    // R9: on-hook clears pickup from the next edge on
    p_pickup_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> !pickup);

    // R8: pickup only rises on an accepted code
    p_pickup_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pickup) |-> $past(smp_vld));

    // R5: idle on-hook cycles keep the verdicts
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !off_hook) |=> ($stable(line_busy) && $stable(line_free)));
endmodule

// File: rtl/line_sense_top.sv
module line_sense_top #(
    parameter int DATA_W     = 8,
    parameter int AVG_LOG2   = 2,
    parameter int SETTLE_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_code,
    input  logic              off_hook,
    input  logic [DATA_W-1:0] busy_thresh,
    input  logic [DATA_W-1:0] trig_margin,
    input  logic [DATA_W-1:0] pickup_margin,
    output logic              line_busy,
    output logic              line_free,
    output logic              pickup
);
    logic              grp_clr;
    logic              grp_take;
    logic              grp_done;
    logic [DATA_W-1:0] grp_mean;

    lsd_avg #(
        .DATA_W  (DATA_W),
        .AVG_LOG2(AVG_LOG2)
    ) u_avg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (grp_clr),
        .take (grp_take),
        .code (smp_code),
        .done (grp_done),
        .mean (grp_mean)
    );

    lsd_ctrl #(
        .DATA_W    (DATA_W),
        .SETTLE_CNT(SETTLE_CNT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld      (smp_vld),
        .smp_code     (smp_code),
        .off_hook     (off_hook),
        .busy_thresh  (busy_thresh),
        .trig_margin  (trig_margin),
        .pickup_margin(pickup_margin),
        .grp_done     (grp_done),
        .grp_mean     (grp_mean),
        .grp_clr      (grp_clr),
        .grp_take     (grp_take),
        .line_busy    (line_busy),
        .line_free    (line_free),
        .pickup       (pickup)
    );
endmodule

// File: tb/tb_line_sense_top.sv
module tb_line_sense_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_code = '0;
    logic       off_hook = 1'b0;
    logic [7:0] busy_thresh = 8'd100;
    logic [7:0] trig_margin = 8'd20;
    logic [7:0] pickup_margin = 8'd30;
    logic       line_busy, line_free, pickup;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    line_sense_top #(.DATA_W(8), .AVG_LOG2(2), .SETTLE_CNT(4)) dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
        .off_hook(off_hook), .busy_thresh(busy_thresh), .trig_margin(trig_margin),
        .pickup_margin(pickup_margin), .line_busy(line_busy), .line_free(line_free),
        .pickup(pickup)
    );

    function automatic int mean4(int a, int b, int c, int d);
        return (a + b + c + d) >> 2;
    endfunction

    function automatic logic [2:0] onhook_exp(int m, int th);
        return (m < th) ? 3'b100 : 3'b010;
    endfunction

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {line_busy, line_free, pickup};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {busy,free,pickup} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send(int c, int gap);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_code = 8'(c);
        @(negedge clk);
        smp_vld  = 1'b0;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic hook(logic v);
        @(negedge clk);
        off_hook = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] prev;
        int s[4];
        int m, rf;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 3'b000);

        // R4: partial group does not change flags
        busy_thresh = 8'd100;
        send(100, 0); send(100, 2); send(100, 0);
        check("R4 partial group", 3'b000);
        send(103, 0);
        check("R3 mean equals threshold", 3'b010);
        send(99, 0); send(100, 0); send(100, 0); send(100, 0);
        check("R2 mean just below threshold", 3'b100);
        repeat (7) @(negedge clk);
        check("R5 idle cycles hold verdict", 3'b100);

        // random on-hook groups
        prev = 3'b100;
        for (int k = 0; k < 20; k++) begin
            busy_thresh = 8'($urandom_range(255));
            for (int j = 0; j < 4; j++) s[j] = $urandom_range(255);
            for (int j = 0; j < 3; j++) send(s[j], $urandom_range(3));
            check("R4 verdict waits for full group", prev);
            send(s[3], $urandom_range(3));
            prev = onhook_exp(mean4(s[0], s[1], s[2], s[3]), busy_thresh);
            check("R2 R3 random group verdict", prev);
        end

        // off-hook: settle discard and reference
        hook(1'b1);
        check("R6 verdicts cleared off-hook", 3'b000);
        for (int j = 0; j < 4; j++) send(10, 0);
        for (int j = 0; j < 4; j++) send(200, 0);
        check("R6 after capture", 3'b000);
        // trigger code 0 excluded: confirm mean == ref - drop -> no pickup
        send(0, 0);
        for (int j = 0; j < 4; j++) send(170, 0);
        check("R7 trigger excluded, R8 boundary no pickup", 3'b000);
        // boundary non-trigger then low codes
        send(180, 0);
        send(40, 0); send(40, 0); send(40, 0); send(200, 0);
        check("R7 boundary code is not a trigger", 3'b000);
        send(200, 0);
        check("R8 pickup confirmed", 3'b001);
        send(255, 0); send(255, 0);
        check("R8 pickup held", 3'b001);
        hook(1'b0);
        check("R9 pickup cleared on-hook", 3'b000);

        // R9: partial group discarded across hook change
        busy_thresh = 8'd150;
        send(0, 0); send(0, 0);
        hook(1'b1);
        hook(1'b0);
        for (int j = 0; j < 4; j++) send(255, 0);
        check("R9 fresh on-hook group", 3'b010);

        // random pickup trials
        for (int k = 0; k < 12; k++) begin
            hook(1'b1);
            for (int j = 0; j < 4; j++) send($urandom_range(255), 0);
            for (int j = 0; j < 4; j++) s[j] = $urandom_range(255, 120);
            for (int j = 0; j < 4; j++) send(s[j], $urandom_range(2));
            rf = mean4(s[0], s[1], s[2], s[3]);
            send(0, 0);
            for (int j = 0; j < 4; j++) s[j] = $urandom_range(255);
            for (int j = 0; j < 4; j++) send(s[j], $urandom_range(2));
            m = mean4(s[0], s[1], s[2], s[3]);
            check("R8 random confirmation", {2'b00, (m + 30 < rf)});
            hook(1'b0);
            check("R9 random on-hook clear", 3'b000);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule